// File: doc/BRIEF.md
# Four-Channel E1 Interleaving Multiplexer

This block joins four 2.048 Mbit/s E1 channels into one single-rail serial stream at 8.192 Mbit/s, and splits such a stream back into four channels. In the forward direction, called rx here, each channel presents the byte for the current time slot. The block serialises the bytes of all four channels into one shared data line and one shared signaling line. In the return direction, called tx, a shared serial data line and a shared signaling line are cut into per-channel bytes. Each byte comes out with its slot number and a one-clock strobe.

Each direction has its own clock and frame-sync pulse. Every channel has its own slice. A 3-bit code tells the slice which of the four interleave positions belongs to it. In the rx direction, each slice drives a zero outside its own position, and the shared line is the OR of all slice outputs. One mode input chooses byte interleaving or bit interleaving for both directions.

A frame holds 1024 bit positions: 32 slots, 4 positions and 8 bits. The frame sync restarts the position count at the first bit of slot 0.

Top module: `e1_quad_interleaver`

## Requirements
- R1: With `mode_i`=0 (byte interleave), frame position n (0..1023) carries slot n/32, interleave position (n/8)%4 and bit (n%8) of that byte. Bits go out MSB first. On `rx_sdat_o`, position n appears in the cycle that follows the clk_rx edge at which the position counter held n.
- R2: With `mode_i`=1 (bit interleave), position n carries slot n/32, interleave position n%4 and bit (n/4)%8 of that byte, MSB first. The rx output timing is the same as in R1.
- R3: When `sync_rx` (or `sync_tx`) is high at a rising clock edge, the counter of that direction restarts at position 0. With no sync, the counter steps by one each clock and wraps from 1023 to 0.
- R4: Channel c takes its phase code from `phase_i[3c+2:3c]`. Codes 000, 001, 010 and 011 assign interleave positions 0, 1, 2 and 3. On the rx lines, the bits of position p come from the channel whose code is p. Channel c's byte for the current slot is read from `rx_dat_i[8c+7:8c]`.
- R5: A phase code from 100 to 111 disables the channel. A disabled slice never drives the rx lines and never raises its strobe. An interleave position that no channel owns reads as 0.
- R6: The signaling line `rx_ssig_o` follows the same ordering and timing as the data line. Its bytes come from `rx_sig_i[8c+7:8c]`.
- R7: In tx, the slice with code p shifts in, MSB first, the bits that arrive at position p. `tx_sdat_i` and `tx_ssig_i` are sampled at the clk_tx edge at which the counter holds the position. At the edge that samples bit 7, the slice loads `tx_dat_o[8c+7:8c]`, `tx_sig_o[8c+7:8c]` and `tx_slot_o[5c+4:5c]`, and raises `tx_valid_o[c]` for exactly one cycle. This holds in both modes.
- R8: `rx_slot_o` gives the slot field (position/32) of the current rx counter.
- R9: While reset is asserted, `rx_sdat_o`, `rx_ssig_o`, `rx_slot_o` and `tx_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released in each clock domain |
| mode_i | input | 1 | 0 = byte interleave, 1 = bit interleave |
| phase_i | input | 12 | Per-channel 3-bit interleave position code |
| clk_rx | input | 1 | Clock for the multiplexing direction |
| sync_rx | input | 1 | Frame-sync pulse for the multiplexing direction |
| rx_dat_i | input | 32 | Per-channel data byte for the current slot |
| rx_sig_i | input | 32 | Per-channel signaling byte for the current slot |
| rx_slot_o | output | 5 | Current slot of the multiplexing counter |
| rx_sdat_o | output | 1 | Multiplexed serial data |
| rx_ssig_o | output | 1 | Multiplexed serial signaling |
| clk_tx | input | 1 | Clock for the demultiplexing direction |
| sync_tx | input | 1 | Frame-sync pulse for the demultiplexing direction |
| tx_sdat_i | input | 1 | Multiplexed serial data in |
| tx_ssig_i | input | 1 | Multiplexed serial signaling in |
| tx_dat_o | output | 32 | Per-channel captured data byte |
| tx_sig_o | output | 32 | Per-channel captured signaling byte |
| tx_slot_o | output | 20 | Per-channel slot number of the captured byte |
| tx_valid_o | output | 4 | Per-channel one-cycle strobe for a completed byte |

## Verification
A position counter that is off by one, or decoded with the wrong field order, shows up on the serial rx line within the first byte after a sync. A bit is taken from the wrong channel or the wrong bit of the byte. A phase decoder that compares the wrong bits either puts two slices on the OR, or leaves one position all zero, and that is visible within the first 32 positions. A bad tx shift or capture point produces a wrong byte, or a strobe in the wrong cycle, at the first completed byte of each channel. Full-frame sweeps in both modes and with several code permutations cover every position. The rx sweeps also run past the wrap, so a faulty frame boundary is caught as well.

// File: rtl/e1q_pkg.sv
package e1q_pkg;
  localparam int unsigned PH_W = 3;

  typedef enum logic {
    ILV_BYTE = 1'b0,
    ILV_BIT  = 1'b1
  } e1q_ilv_e;
endpackage

// File: rtl/e1q_rst_sync.sv
module e1q_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_sn = sr_q[1];
endmodule

// File: rtl/e1q_frame_counter.sv
module e1q_frame_counter
  import e1q_pkg::*;
#(
  parameter int unsigned CH_W   = 2,
  parameter int unsigned BIT_W  = 3,
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned CNT_W  = SLOT_W + CH_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  e1q_ilv_e          mode_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [BIT_W-1:0]  bit_o
);
  localparam int unsigned LOW_W = CH_W + BIT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [LOW_W-1:0] low;

  assign cnt_en = 1'b1;

  always_comb begin
    if (sync_i) cnt_d = '0;
    else        cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign low    = cnt_q[LOW_W-1:0];
  assign slot_o = cnt_q[CNT_W-1 -: SLOT_W];
  assign cnt_o  = cnt_q;

  always_comb begin
    if (mode_i == ILV_BIT) begin
      chan_o = low[CH_W-1:0];
      bit_o  = low[CH_W +: BIT_W];
    end else begin
      chan_o = low[BIT_W +: CH_W];
      bit_o  = low[BIT_W-1:0];
    end
  end
endmodule

// File: rtl/e1q_rx_slice.sv
module e1q_rx_slice
  import e1q_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned BIT_W  = 3
) (
  input  logic [PH_W-1:0]   phase_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [BYTE_W-1:0] dat_i,
  input  logic [BYTE_W-1:0] sig_i,
  output logic              act_o,
  output logic              dat_o,
  output logic              sig_o
);
  logic [BIT_W-1:0] idx;

  // a code equal to the current position can only be an enabled one
  assign act_o = (PH_W'(chan_i) == phase_i);
  assign idx   = BIT_W'(BYTE_W - 1) - bit_i;
  assign dat_o = act_o & dat_i[idx];
  assign sig_o = act_o & sig_i[idx];
endmodule

// File: rtl/e1q_tx_slice.sv
module e1q_tx_slice
  import e1q_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned BIT_W  = 3,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   phase_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              dat_i,
  input  logic              sig_i,
  output logic [BYTE_W-1:0] dat_o,
  output logic [BYTE_W-1:0] sig_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              valid_o
);
  logic [BYTE_W-2:0] sh_dat_q, sh_dat_d, sh_sig_q, sh_sig_d;
  logic [BYTE_W-1:0] out_dat_q, out_dat_d, out_sig_q, out_sig_d;
  logic [SLOT_W-1:0] out_slot_q;
  logic              valid_q, valid_d;
  logic              cap_en, done_en, last;

  assign last    = (bit_i == BIT_W'(BYTE_W - 1));
  assign cap_en  = (PH_W'(chan_i) == phase_i);
  assign done_en = cap_en & last;

  always_comb begin
    sh_dat_d  = {sh_dat_q[BYTE_W-3:0], dat_i};
    sh_sig_d  = {sh_sig_q[BYTE_W-3:0], sig_i};
    out_dat_d = {sh_dat_q, dat_i};
    out_sig_d = {sh_sig_q, sig_i};
    valid_d   = done_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_dat_q <= '0;
      sh_sig_q <= '0;
    end else if (cap_en) begin
      sh_dat_q <= sh_dat_d;
      sh_sig_q <= sh_sig_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_dat_q  <= '0;
      out_sig_q  <= '0;
      out_slot_q <= '0;
    end else if (done_en) begin
      out_dat_q  <= out_dat_d;
      out_sig_q  <= out_sig_d;
      out_slot_q <= slot_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign dat_o   = out_dat_q;
  assign sig_o   = out_sig_q;
  assign slot_o  = out_slot_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/e1_quad_interleaver.sv
module e1_quad_interleaver
  import e1q_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                         rst_n,
  input  logic                         mode_i,
  input  logic [NCH*PH_W-1:0]          phase_i,
  input  logic                         clk_rx,
  input  logic                         sync_rx,
  input  logic [NCH*BYTE_W-1:0]        rx_dat_i,
  input  logic [NCH*BYTE_W-1:0]        rx_sig_i,
  output logic [$clog2(SLOTS)-1:0]     rx_slot_o,
  output logic                         rx_sdat_o,
  output logic                         rx_ssig_o,
  input  logic                         clk_tx,
  input  logic                         sync_tx,
  input  logic                         tx_sdat_i,
  input  logic                         tx_ssig_i,
  output logic [NCH*BYTE_W-1:0]        tx_dat_o,
  output logic [NCH*BYTE_W-1:0]        tx_sig_o,
  output logic [NCH*$clog2(SLOTS)-1:0] tx_slot_o,
  output logic [NCH-1:0]               tx_valid_o
);
  localparam int unsigned CH_W   = $clog2(NCH);
  localparam int unsigned BIT_W  = $clog2(BYTE_W);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned CNT_W  = SLOT_W + CH_W + BIT_W;

  e1q_ilv_e          mode;
  logic              rst_rx_sn, rst_tx_sn;
  logic [CNT_W-1:0]  rx_cnt, tx_cnt;
  logic [SLOT_W-1:0] rx_slot, tx_slot;
  logic [CH_W-1:0]   rx_chan, tx_chan;
  logic [BIT_W-1:0]  rx_bit, tx_bit;
  logic [NCH-1:0]    rx_act, rx_dbit, rx_sbit;
  logic              rdo_q, rdo_d, rso_q, rso_d;

  assign mode = e1q_ilv_e'(mode_i);

  e1q_rst_sync u_rst_rx (.clk(clk_rx), .rst_n(rst_n), .rst_sn(rst_rx_sn));
  e1q_rst_sync u_rst_tx (.clk(clk_tx), .rst_n(rst_n), .rst_sn(rst_tx_sn));

  e1q_frame_counter #(.CH_W(CH_W), .BIT_W(BIT_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_cnt_rx (
    .clk(clk_rx), .rst_n(rst_rx_sn), .sync_i(sync_rx), .mode_i(mode),
    .cnt_o(rx_cnt), .slot_o(rx_slot), .chan_o(rx_chan), .bit_o(rx_bit)
  );

  e1q_frame_counter #(.CH_W(CH_W), .BIT_W(BIT_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_cnt_tx (
    .clk(clk_tx), .rst_n(rst_tx_sn), .sync_i(sync_tx), .mode_i(mode),
    .cnt_o(tx_cnt), .slot_o(tx_slot), .chan_o(tx_chan), .bit_o(tx_bit)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    e1q_rx_slice #(.BYTE_W(BYTE_W), .CH_W(CH_W), .BIT_W(BIT_W)) u_rx (
      .phase_i(phase_i[c*PH_W +: PH_W]),
      .chan_i (rx_chan),
      .bit_i  (rx_bit),
      .dat_i  (rx_dat_i[c*BYTE_W +: BYTE_W]),
      .sig_i  (rx_sig_i[c*BYTE_W +: BYTE_W]),
      .act_o  (rx_act[c]),
      .dat_o  (rx_dbit[c]),
      .sig_o  (rx_sbit[c])
    );

    e1q_tx_slice #(.BYTE_W(BYTE_W), .CH_W(CH_W), .BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_tx (
      .clk    (clk_tx),
      .rst_n  (rst_tx_sn),
      .phase_i(phase_i[c*PH_W +: PH_W]),
      .chan_i (tx_chan),
      .bit_i  (tx_bit),
      .slot_i (tx_slot),
      .dat_i  (tx_sdat_i),
      .sig_i  (tx_ssig_i),
      .dat_o  (tx_dat_o[c*BYTE_W +: BYTE_W]),
      .sig_o  (tx_sig_o[c*BYTE_W +: BYTE_W]),
      .slot_o (tx_slot_o[c*SLOT_W +: SLOT_W]),
      .valid_o(tx_valid_o[c])
    );
  end

  // shared line: OR of every slice, each zero outside its own position
  always_comb begin
    rdo_d = |rx_dbit;
    rso_d = |rx_sbit;
  end

  always_ff @(posedge clk_rx or negedge rst_rx_sn) begin
    if (!rst_rx_sn) begin
      rdo_q <= 1'b0;
      rso_q <= 1'b0;
    end else begin
      rdo_q <= rdo_d;
      rso_q <= rso_d;
    end
  end

  assign rx_sdat_o = rdo_q;
  assign rx_ssig_o = rso_q;
  assign rx_slot_o = rx_slot;
endmodule

// File: rtl/e1q_chk.sv
module e1q_chk
  import e1q_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = 10
) (
  input logic                clk_rx,
  input logic                clk_tx,
  input logic                rst_rx_n,
  input logic                rst_tx_n,
  input logic                mode_i,
  input logic [NCH*PH_W-1:0] phase_i,
  input logic                sync_rx,
  input logic                sync_tx,
  input logic [CNT_W-1:0]    rx_cnt,
  input logic [CNT_W-1:0]    tx_cnt,
  input logic [NCH-1:0]      rx_act,
  input logic                rx_sdat_o,
  input logic                rx_ssig_o,
  input logic [NCH-1:0]      tx_valid_o
);
  logic distinct, all_off;

  always_comb begin
    distinct = 1'b1;
    all_off  = 1'b1;
    for (int a = 0; a < NCH; a++) begin
      if (phase_i[a*PH_W +: PH_W] < PH_W'(NCH)) all_off = 1'b0;
      for (int b = a + 1; b < NCH; b++)
        if (phase_i[a*PH_W +: PH_W] == phase_i[b*PH_W +: PH_W]) distinct = 1'b0;
    end
  end

  AST_RX_SINGLE_DRIVER: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    distinct |-> $onehot0(rx_act)) else $error("two slices drive the shared line"); // R4

  AST_RX_SYNC_RESTART: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    sync_rx |=> (rx_cnt == '0)) else $error("rx sync did not restart"); // R3

  AST_RX_CNT_STEP: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    !sync_rx |=> (rx_cnt == $past(rx_cnt) + CNT_W'(1))) else $error("rx count step"); // R3

  AST_TX_SYNC_RESTART: assert property (@(posedge clk_tx) disable iff (!rst_tx_n)
    sync_tx |=> (tx_cnt == '0)) else $error("tx sync did not restart"); // R3

  AST_RX_DISABLED_QUIET: assert property (@(posedge clk_rx) disable iff (!rst_rx_n)
    all_off |=> (!rx_sdat_o && !rx_ssig_o)) else $error("disabled slices drove"); // R5

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_TX_DISABLED_NO_STROBE: assert property (@(posedge clk_tx) disable iff (!rst_tx_n)
      (phase_i[c*PH_W +: PH_W] >= PH_W'(NCH)) |=> !tx_valid_o[c])
      else $error("disabled slice strobed"); // R5

    AST_TX_STROBE_ONE_CYCLE: assert property (@(posedge clk_tx) disable iff (!rst_tx_n)
      tx_valid_o[c] |=> (!tx_valid_o[c] || !$stable(mode_i) || !$stable(phase_i)))
      else $error("strobe longer than one cycle"); // R7
  end
endmodule

bind e1_quad_interleaver e1q_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk_rx    (clk_rx),
  .clk_tx    (clk_tx),
  .rst_rx_n  (rst_rx_sn),
  .rst_tx_n  (rst_tx_sn),
  .mode_i    (mode_i),
  .phase_i   (phase_i),
  .sync_rx   (sync_rx),
  .sync_tx   (sync_tx),
  .rx_cnt    (rx_cnt),
  .tx_cnt    (tx_cnt),
  .rx_act    (rx_act),
  .rx_sdat_o (rx_sdat_o),
  .rx_ssig_o (rx_ssig_o),
  .tx_valid_o(tx_valid_o)
);

// File: tb/e1_quad_interleaver_tb_top.sv
module e1_quad_interleaver_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        rst_n, mode_i, clk_rx, clk_tx, sync_rx, sync_tx;
  logic [11:0] phase_i;
  logic [31:0] rx_dat_i, rx_sig_i, tx_dat_o, tx_sig_o;
  logic [4:0]  rx_slot_o;
  logic        rx_sdat_o, rx_ssig_o, tx_sdat_i, tx_ssig_i;
  logic [19:0] tx_slot_o;
  logic [3:0]  tx_valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int ph [4];

  e1_quad_interleaver dut_i (
    .rst_n(rst_n), .mode_i(mode_i), .phase_i(phase_i),
    .clk_rx(clk_rx), .sync_rx(sync_rx), .rx_dat_i(rx_dat_i), .rx_sig_i(rx_sig_i),
    .rx_slot_o(rx_slot_o), .rx_sdat_o(rx_sdat_o), .rx_ssig_o(rx_ssig_o),
    .clk_tx(clk_tx), .sync_tx(sync_tx), .tx_sdat_i(tx_sdat_i), .tx_ssig_i(tx_ssig_i),
    .tx_dat_o(tx_dat_o), .tx_sig_o(tx_sig_o), .tx_slot_o(tx_slot_o), .tx_valid_o(tx_valid_o)
  );

  initial begin
    clk_rx = 1'b0;
    forever #(CLK_PERIOD/2) clk_rx = ~clk_rx;
  end

  initial begin
    clk_tx = 1'b0;
    #3;
    forever #(CLK_PERIOD/2) clk_tx = ~clk_tx;
  end

  function automatic logic [7:0] rx_byte(int c, int s);
    logic [7:0] v;
    v = 8'(c*67 + s*29 + 13);
    return v ^ 8'(s << 3);
  endfunction

  function automatic logic [7:0] rx_sbyte(int c, int s);
    return 8'(c*41 + s*5 + 163);
  endfunction

  function automatic logic [7:0] tx_byte(int p, int s);
    logic [7:0] v;
    v = 8'(p*59 + s*23 + 7);
    return v ^ 8'h5A;
  endfunction

  function automatic logic [7:0] tx_sbyte(int p, int s);
    return 8'(p*17 + s*31 + 3);
  endfunction

  // channel bytes follow the slot shown by the block (R4, R6)
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      rx_dat_i[c*8 +: 8] = rx_byte(c, int'(rx_slot_o));
      rx_sig_i[c*8 +: 8] = rx_sbyte(c, int'(rx_slot_o));
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic decode(input int n, input bit bm, output int s, output int p, output int b);
    int m;
    m = n % 1024;
    s = m / 32;
    if (bm) begin p = m % 4; b = (m / 4) % 8; end
    else    begin p = (m / 8) % 4; b = m % 8; end
  endtask

  function automatic int owner(int p);
    for (int c = 0; c < 4; c++) if (ph[c] == p) return c;
    return -1;
  endfunction

  task automatic setup(bit bm, int c0, int c1, int c2, int c3);
    ph[0] = c0; ph[1] = c1; ph[2] = c2; ph[3] = c3;
    mode_i = bm;
    for (int c = 0; c < 4; c++) phase_i[c*3 +: 3] = 3'(ph[c]);
  endtask

  task automatic run_rx(bit bm, int c0, int c1, int c2, int c3);
    int s, p, b, o;
    logic ed, es;
    @(negedge clk_rx);
    setup(bm, c0, c1, c2, c3);
    sync_rx = 1'b1;
    @(negedge clk_rx);
    sync_rx = 1'b0;
    for (int n = 0; n < 1024 + 40; n++) begin
      @(negedge clk_rx);
      decode(n, bm, s, p, b);
      o = owner(p);
      ed = (o < 0) ? 1'b0 : rx_byte(o, s)[7-b];
      es = (o < 0) ? 1'b0 : rx_sbyte(o, s)[7-b];
      if (bm) chk("R2 rx data order", int'(rx_sdat_o), int'(ed));
      else    chk("R1 rx data order", int'(rx_sdat_o), int'(ed));
      if (o < 0) chk("R5 unowned position", int'(rx_sdat_o | rx_ssig_o), 0);
      chk("R6 rx signaling order", int'(rx_ssig_o), int'(es));
      chk("R8 rx slot", int'(rx_slot_o), ((n + 1) % 1024) / 32);
      if (n >= 1024) chk("R3 wrap", int'(rx_sdat_o), int'(ed));
    end
  endtask

  task automatic run_tx(bit bm, int c0, int c1, int c2, int c3);
    int s, p, b, nv [4];
    bit ev;
    @(negedge clk_tx);
    setup(bm, c0, c1, c2, c3);
    sync_tx = 1'b1;
    @(negedge clk_tx);
    sync_tx = 1'b0;
    for (int c = 0; c < 4; c++) nv[c] = 0;
    for (int n = 0; n < 1024; n++) begin
      decode(n, bm, s, p, b);
      tx_sdat_i = tx_byte(p, s)[7-b];
      tx_ssig_i = tx_sbyte(p, s)[7-b];
      @(negedge clk_tx);
      for (int c = 0; c < 4; c++) begin
        ev = (ph[c] == p) && (b == 7);
        if (ph[c] >= 4) chk("R5 disabled no strobe", int'(tx_valid_o[c]), 0);
        else            chk("R7 strobe timing", int'(tx_valid_o[c]), int'(ev));
        if (tx_valid_o[c]) nv[c]++;
        if (ev) begin
          chk("R7 tx data byte", int'(tx_dat_o[c*8 +: 8]), int'(tx_byte(p, s)));
          chk("R7 tx sig byte", int'(tx_sig_o[c*8 +: 8]), int'(tx_sbyte(p, s)));
          chk("R7 tx slot", int'(tx_slot_o[c*5 +: 5]), s);
        end
      end
    end
    for (int c = 0; c < 4; c++)
      chk("R7 strobes per frame", nv[c], (ph[c] < 4) ? 32 : 0);
  endtask

  initial begin
    rst_n = 1'b0;
    sync_rx = 1'b0; sync_tx = 1'b0;
    tx_sdat_i = 1'b0; tx_ssig_i = 1'b0;
    setup(1'b0, 0, 1, 2, 3);
    #(CLK_PERIOD*3 + 2);
    chk("R9 reset rx data", int'(rx_sdat_o), 0);
    chk("R9 reset rx sig", int'(rx_ssig_o), 0);
    chk("R9 reset slot", int'(rx_slot_o), 0);
    chk("R9 reset strobes", int'(tx_valid_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_rx);

    run_rx(1'b0, 0, 1, 2, 3);
    run_rx(1'b0, 2, 0, 3, 1);
    run_rx(1'b1, 3, 2, 1, 0);
    run_rx(1'b0, 1, 7, 0, 4);
    run_rx(1'b1, 5, 3, 6, 0);

    run_tx(1'b0, 0, 1, 2, 3);
    run_tx(1'b0, 3, 1, 0, 2);
    run_tx(1'b1, 1, 2, 3, 0);
    run_tx(1'b0, 6, 2, 4, 1);
    run_tx(1'b1, 0, 5, 7, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule